// File: doc/BRIEF.md
# Programmable Peripheral Base Address Decoder

This block turns a 10-bit I/O address into chip-selects for four legacy peripherals: a floppy controller, two serial ports and a parallel port. Each peripheral has a base address field and an enable, both supplied by configuration registers held outside the block. During an I/O read or write the address is compared with every programmed base. The number of address bits compared depends on the size of that peripheral's window: 16 bytes for the floppy controller, 8 bytes for each serial port, and 4 or 8 bytes for the parallel port, depending on its mode.

The decode is purely combinational. The block drives at most one chip-select at a time and also returns the byte offset inside the selected window. Programmed windows may overlap. In that case a fixed priority picks the winner: floppy, then serial 1, then serial 2, then parallel.

Top module: `sio_base_decoder`

## Requirements
- R1: `fdc_cs` is 1 when `fdc_en`=1, a strobe is active and `io_addr[9:4]` equals `fdc_base`; `win_ofs` then equals `io_addr[3:0]`.
- R2: `com1_cs` (or `com2_cs`) is 1 when its enable is 1, a strobe is active and `io_addr[9:3]` equals `com1_base` (or `com2_base`); `win_ofs` then equals {1'b0, `io_addr[2:0]`}.
- R3: With `lpt_mode` 00 (standard) or 01 (extended capability), `lpt_cs` is 1 when a strobe is active and `io_addr[9:2]` equals `lpt_base`; `win_ofs` then equals {2'b00, `io_addr[1:0]`}.
- R4: With `lpt_mode` 10 (enhanced parallel), the window is 8 bytes. `lpt_cs` is 1 when `io_addr[9:3]` equals `lpt_base[7:1]`, and `lpt_base[0]` (address bit 2) is ignored. `win_ofs` then equals {1'b0, `io_addr[2:0]`}.
- R5: With `lpt_mode` 11 the parallel port is disabled, and `lpt_cs` stays 0 for every address.
- R6: A parallel base whose address is below 100h gives no decode. This means `lpt_base` < 40h in modes 00 and 01, and `lpt_base[7:1]` < 20h in mode 10.
- R7: When `io_rd` and `io_wr` are both 0, every chip-select is 0 and `win_ofs` is 0.
- R8: At most one chip-select is 1. When windows overlap, the priority is floppy, then serial 1, then serial 2, then parallel.
- R9: A peripheral whose enable is 0 never drives its chip-select, whatever the address.
- R10: When no chip-select is 1, `win_ofs` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| io_addr | input | 10 | I/O address |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| fdc_en | input | 1 | Floppy controller enable |
| com1_en | input | 1 | Serial port 1 enable |
| com2_en | input | 1 | Serial port 2 enable |
| lpt_mode | input | 2 | Parallel mode: 00 standard, 01 extended capability, 10 enhanced parallel, 11 off |
| fdc_base | input | 6 | Floppy base, address bits 9:4 |
| com1_base | input | 7 | Serial 1 base, address bits 9:3 |
| com2_base | input | 7 | Serial 2 base, address bits 9:3 |
| lpt_base | input | 8 | Parallel base, address bits 9:2 |
| fdc_cs | output | 1 | Floppy chip-select |
| com1_cs | output | 1 | Serial 1 chip-select |
| com2_cs | output | 1 | Serial 2 chip-select |
| lpt_cs | output | 1 | Parallel chip-select |
| win_ofs | output | 4 | Byte offset inside the selected window |

## Verification
Every output is combinational, so each result is due in the same cycle as the stimulus that causes it, with no register in between. The bench changes the inputs just after a rising clock edge and samples all five outputs at the following falling edge, half a period later, once the logic has settled. Random vectors, often aimed inside a programmed window, are compared against a bench function. Directed vectors cover overlapping windows, the disabled parallel mode, bases below 100h, and the address bit that the enhanced parallel mode ignores.

// File: rtl/sio_dec_pkg.sv
package sio_dec_pkg;
   typedef enum logic [1:0] {
      LPT_STD = 2'b00,
      LPT_ECP = 2'b01,
      LPT_EPP = 2'b10,
      LPT_OFF = 2'b11
   } lpt_mode_e;

   // arbitration slot order = priority order (lowest index wins)
   localparam int SLOT_FDC  = 0;
   localparam int SLOT_COM1 = 1;
   localparam int SLOT_COM2 = 2;
   localparam int SLOT_LPT  = 3;
   localparam int N_SLOTS   = 4;
endpackage

// File: rtl/sio_win_match.sv
module sio_win_match #(
   parameter int ADDR_W     = 10,
   parameter int LSB        = 3,
   parameter int OFS_W      = 4,
   parameter int FLOOR_ADDR = 0
) (
   input  logic [ADDR_W-1:0]     addr,
   input  logic [ADDR_W-LSB-1:0] base,
   input  logic                  en,
   input  logic                  strobe,
   output logic                  hit,
   output logic [OFS_W-1:0]      ofs
);
   localparam int BASE_W      = ADDR_W - LSB;
   localparam int FLOOR_FIELD = FLOOR_ADDR >> LSB;

   if (LSB < 1 || LSB >= ADDR_W) begin : g_bad_lsb
      $error("sio_win_match: LSB out of range");
   end
   if (OFS_W < LSB) begin : g_bad_ofs
      $error("sio_win_match: OFS_W narrower than window");
   end

   logic floor_ok;
   if (FLOOR_ADDR > 0) begin : g_floor
      assign floor_ok = (base >= BASE_W'(FLOOR_FIELD));
   end else begin : g_no_floor
      assign floor_ok = 1'b1;
   end

   always_comb begin
      hit = en && strobe && floor_ok && (addr[ADDR_W-1:LSB] == base);
      ofs = hit ? OFS_W'(addr[LSB-1:0]) : '0;
      AST_HIT_NEEDS_STROBE: assert (!hit || strobe)
         else $error("window hit without strobe"); // R7
      AST_DISABLED_QUIET: assert (!hit || en)
         else $error("window hit while disabled"); // R9
   end
endmodule

// File: rtl/sio_lpt_match.sv
module sio_lpt_match
   import sio_dec_pkg::*;
#(
   parameter int ADDR_W     = 10,
   parameter int NARROW_LSB = 2,
   parameter int WIDE_LSB   = 3,
   parameter int OFS_W      = 4,
   parameter int FLOOR_ADDR = 'h100
) (
   input  logic [ADDR_W-1:0]            addr,
   input  logic [ADDR_W-NARROW_LSB-1:0] base,
   input  lpt_mode_e                    mode,
   input  logic                         strobe,
   output logic                         hit,
   output logic [OFS_W-1:0]             ofs
);
   localparam int DROP = WIDE_LSB - NARROW_LSB;

   if (DROP < 1) begin : g_bad_widths
      $error("sio_lpt_match: wide window must exceed narrow window");
   end

   logic                   narrow_en, wide_en;
   logic                   narrow_hit, wide_hit;
   logic [OFS_W-1:0]       narrow_ofs, wide_ofs;

   assign narrow_en = (mode == LPT_STD) || (mode == LPT_ECP);
   assign wide_en   = (mode == LPT_EPP);

   sio_win_match #(.ADDR_W(ADDR_W), .LSB(NARROW_LSB), .OFS_W(OFS_W),
                   .FLOOR_ADDR(FLOOR_ADDR)) u_narrow (
      .addr(addr), .base(base), .en(narrow_en), .strobe(strobe),
      .hit(narrow_hit), .ofs(narrow_ofs));

   // the low DROP field bits are ignored: window snaps to the wide boundary
   sio_win_match #(.ADDR_W(ADDR_W), .LSB(WIDE_LSB), .OFS_W(OFS_W),
                   .FLOOR_ADDR(FLOOR_ADDR)) u_wide (
      .addr(addr), .base(base[ADDR_W-NARROW_LSB-1:DROP]), .en(wide_en),
      .strobe(strobe), .hit(wide_hit), .ofs(wide_ofs));

   always_comb begin
      hit = narrow_hit || wide_hit;
      ofs = narrow_ofs | wide_ofs;
      AST_LPT_OFF_SILENT: assert (!(mode == LPT_OFF && hit))
         else $error("parallel decode while off"); // R5
      AST_LPT_SINGLE_SIZE: assert (!(narrow_hit && wide_hit))
         else $error("both parallel window sizes hit"); // R4
   end
endmodule

// File: rtl/sio_cs_arb.sv
module sio_cs_arb #(
   parameter int N     = 4,
   parameter int OFS_W = 4
) (
   input  logic [N-1:0]     hit,
   input  logic [OFS_W-1:0] ofs_in [N],
   output logic [N-1:0]     cs,
   output logic [OFS_W-1:0] ofs
);
   if (N < 1) begin : g_bad_n
      $error("sio_cs_arb: N must be positive");
   end

   logic taken;

   always_comb begin
      cs    = '0;
      ofs   = '0;
      taken = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (hit[i] && !taken) begin
            cs[i] = 1'b1;
            ofs   = ofs_in[i];
            taken = 1'b1;
         end
      end
      AST_CS_ONEHOT: assert ($onehot0(cs))
         else $error("chip-selects not one-hot"); // R8
      AST_TOP_SLOT_WINS: assert (!hit[0] || cs[0])
         else $error("highest priority hit lost"); // R8
      AST_IDLE_OFS_ZERO: assert (cs != '0 || ofs == '0)
         else $error("offset nonzero with no select"); // R10
   end
endmodule

// File: rtl/sio_base_decoder.sv
module sio_base_decoder
   import sio_dec_pkg::*;
#(
   parameter int ADDR_W     = 10,
   parameter int FDC_LSB    = 4,
   parameter int COM_LSB    = 3,
   parameter int LPT_LSB    = 2,
   parameter int LPT_WIDE   = 3,
   parameter int OFS_W      = 4,
   parameter int LPT_FLOOR  = 'h100
) (
   input  logic [ADDR_W-1:0]         io_addr,
   input  logic                      io_rd,
   input  logic                      io_wr,
   input  logic                      fdc_en,
   input  logic                      com1_en,
   input  logic                      com2_en,
   input  logic [1:0]                lpt_mode,
   input  logic [ADDR_W-FDC_LSB-1:0] fdc_base,
   input  logic [ADDR_W-COM_LSB-1:0] com1_base,
   input  logic [ADDR_W-COM_LSB-1:0] com2_base,
   input  logic [ADDR_W-LPT_LSB-1:0] lpt_base,
   output logic                      fdc_cs,
   output logic                      com1_cs,
   output logic                      com2_cs,
   output logic                      lpt_cs,
   output logic [OFS_W-1:0]          win_ofs
);
   if (OFS_W < FDC_LSB || OFS_W < COM_LSB || OFS_W < LPT_WIDE) begin : g_bad_ofs
      $error("sio_base_decoder: OFS_W too narrow");
   end

   logic                 strobe;
   logic [N_SLOTS-1:0]   hit;
   logic [N_SLOTS-1:0]   cs;
   logic [OFS_W-1:0]     ofs_slot [N_SLOTS];
   lpt_mode_e            mode;

   assign strobe = io_rd || io_wr;
   assign mode   = lpt_mode_e'(lpt_mode);

   sio_win_match #(.ADDR_W(ADDR_W), .LSB(FDC_LSB), .OFS_W(OFS_W)) u_fdc (
      .addr(io_addr), .base(fdc_base), .en(fdc_en), .strobe(strobe),
      .hit(hit[SLOT_FDC]), .ofs(ofs_slot[SLOT_FDC]));

   sio_win_match #(.ADDR_W(ADDR_W), .LSB(COM_LSB), .OFS_W(OFS_W)) u_com1 (
      .addr(io_addr), .base(com1_base), .en(com1_en), .strobe(strobe),
      .hit(hit[SLOT_COM1]), .ofs(ofs_slot[SLOT_COM1]));

   sio_win_match #(.ADDR_W(ADDR_W), .LSB(COM_LSB), .OFS_W(OFS_W)) u_com2 (
      .addr(io_addr), .base(com2_base), .en(com2_en), .strobe(strobe),
      .hit(hit[SLOT_COM2]), .ofs(ofs_slot[SLOT_COM2]));

   sio_lpt_match #(.ADDR_W(ADDR_W), .NARROW_LSB(LPT_LSB), .WIDE_LSB(LPT_WIDE),
                   .OFS_W(OFS_W), .FLOOR_ADDR(LPT_FLOOR)) u_lpt (
      .addr(io_addr), .base(lpt_base), .mode(mode), .strobe(strobe),
      .hit(hit[SLOT_LPT]), .ofs(ofs_slot[SLOT_LPT]));

   sio_cs_arb #(.N(N_SLOTS), .OFS_W(OFS_W)) u_arb (
      .hit(hit), .ofs_in(ofs_slot), .cs(cs), .ofs(win_ofs));

   assign fdc_cs  = cs[SLOT_FDC];
   assign com1_cs = cs[SLOT_COM1];
   assign com2_cs = cs[SLOT_COM2];
   assign lpt_cs  = cs[SLOT_LPT];
endmodule

// File: tb/tb_sio_base_decoder.sv
module tb_sio_base_decoder;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] io_addr = '0;
   logic       io_rd = 1'b0, io_wr = 1'b0;
   logic       fdc_en = 1'b0, com1_en = 1'b0, com2_en = 1'b0;
   logic [1:0] lpt_mode = 2'b11;
   logic [5:0] fdc_base = '0;
   logic [6:0] com1_base = '0, com2_base = '0;
   logic [7:0] lpt_base = '0;
   logic       fdc_cs, com1_cs, com2_cs, lpt_cs;
   logic [3:0] win_ofs;

   int n_vec = 0, n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk; // 50 MHz

   sio_base_decoder dut (.*);

   // expected {lpt,com2,com1,fdc, ofs[3:0]}
   function automatic logic [7:0] model();
      logic       stb = io_rd | io_wr;
      logic [3:0] h = '0;
      logic [3:0] o [4];
      o[0] = io_addr[3:0];
      o[1] = {1'b0, io_addr[2:0]};
      o[2] = {1'b0, io_addr[2:0]};
      o[3] = (lpt_mode == 2'b10) ? {1'b0, io_addr[2:0]} : {2'b00, io_addr[1:0]};
      h[0] = stb && fdc_en && io_addr[9:4] == fdc_base;
      h[1] = stb && com1_en && io_addr[9:3] == com1_base;
      h[2] = stb && com2_en && io_addr[9:3] == com2_base;
      if (lpt_mode == 2'b10)
         h[3] = stb && lpt_base[7:1] >= 7'h20 && io_addr[9:3] == lpt_base[7:1];
      else if (lpt_mode != 2'b11)
         h[3] = stb && lpt_base >= 8'h40 && io_addr[9:2] == lpt_base;
      for (int i = 0; i < 4; i++)
         if (h[i]) return {4'(1 << i), o[i]};
      return 8'h00;
   endfunction

   task automatic check(input string tag);
      logic [7:0] exp, act;
      @(negedge clk);
      exp = model();
      act = {lpt_cs, com2_cs, com1_cs, fdc_cs, win_ofs};
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s addr=%h mode=%b act cs=%b ofs=%h exp cs=%b ofs=%h",
                  tag, io_addr, lpt_mode, act[7:4], act[3:0], exp[7:4], exp[3:0]);
      end
      @(posedge clk);
   endtask

   function automatic string auto_tag();
      logic [7:0] e = model();
      if (e[4]) return "R1";
      if (e[5] || e[6]) return "R2";
      if (e[7]) return (lpt_mode == 2'b10) ? "R4" : "R3";
      return "R10";
   endfunction

   task automatic cfg(input logic fe, c1e, c2e, input logic [1:0] m,
                      input logic [5:0] fb, input logic [6:0] c1b, c2b,
                      input logic [7:0] lb);
      fdc_en = fe; com1_en = c1e; com2_en = c2e; lpt_mode = m;
      fdc_base = fb; com1_base = c1b; com2_base = c2b; lpt_base = lb;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = 7;
      void'($urandom(seed));
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(posedge clk);

      // reset / idle state
      check("R7 idle after reset");

      // R1: floppy at 3F0h, every offset
      cfg(1, 0, 0, 2'b11, 6'h3F, 0, 0, 0);
      io_rd = 1;
      for (int k = 0; k < 16; k++) begin io_addr = 10'h3F0 + 10'(k); check("R1 floppy offset"); end
      io_addr = 10'h3E0; check("R1 floppy miss");

      // R2: serial ports at 3F8h / 2F8h
      cfg(0, 1, 1, 2'b11, 0, 7'h7F, 7'h5F, 0);
      io_rd = 0; io_wr = 1;
      io_addr = 10'h3FD; check("R2 serial 1 offset 5");
      io_addr = 10'h2FF; check("R2 serial 2 offset 7");

      // R3: standard mode at 378h, address 37Ah; outside 37Ch
      cfg(0, 0, 0, 2'b00, 0, 0, 0, 8'hDE);
      io_addr = 10'h37A; check("R3 standard in window");
      io_addr = 10'h37C; check("R3 standard outside 4-byte window");
      lpt_mode = 2'b01; io_addr = 10'h379; check("R3 extended capability");

      // R4: enhanced mode, base 37Ch (bit 2 set) snaps to 378h
      cfg(0, 0, 0, 2'b10, 0, 0, 0, 8'hDF);
      io_addr = 10'h378; check("R4 base bit 2 ignored");
      io_addr = 10'h37F; check("R4 offset 7");

      // R5: mode off
      cfg(0, 0, 0, 2'b11, 0, 0, 0, 8'hDE);
      io_addr = 10'h378; check("R5 parallel off");

      // R6: base below 100h
      cfg(0, 0, 0, 2'b00, 0, 0, 0, 8'h3F);
      io_addr = 10'h0FC; check("R6 low base standard");
      cfg(0, 0, 0, 2'b10, 0, 0, 0, 8'h3E);
      io_addr = 10'h0F8; check("R6 low base enhanced");
      cfg(0, 0, 0, 2'b00, 0, 0, 0, 8'h40);
      io_addr = 10'h100; check("R6 base exactly 100h decodes");

      // R8: overlap priority
      cfg(1, 1, 1, 2'b00, 6'h3F, 7'h7E, 7'h7E, 8'hFC);
      io_addr = 10'h3F1; check("R8 floppy beats serial and parallel");
      fdc_en = 0; check("R8 serial 1 beats serial 2 and parallel");
      com1_en = 0; check("R8 serial 2 beats parallel");
      com2_en = 0; check("R8 parallel last");

      // R9: enables cleared
      cfg(0, 0, 0, 2'b11, 6'h3F, 7'h7F, 7'h7F, 0);
      io_addr = 10'h3F8; check("R9 all disabled");

      // R7: no strobe with a matching window
      cfg(1, 1, 1, 2'b00, 6'h3F, 7'h7F, 7'h5F, 8'hDE);
      io_rd = 0; io_wr = 0; io_addr = 10'h3F2; check("R7 no strobe");

      // constrained random
      for (int n = 0; n < 3000; n++) begin
         cfg($urandom_range(1), $urandom_range(1), $urandom_range(1),
             2'($urandom_range(3)), 6'($urandom), 7'($urandom), 7'($urandom),
             8'($urandom));
         io_rd = $urandom_range(3) != 0;
         io_wr = $urandom_range(1);
         case ($urandom_range(5))
            0: io_addr = {fdc_base, 4'($urandom)};
            1: io_addr = {com1_base, 3'($urandom)};
            2: io_addr = {com2_base, 3'($urandom)};
            3: io_addr = {lpt_base[7:1], 3'($urandom)};
            4: io_addr = {lpt_base, 2'($urandom)};
            default: io_addr = 10'($urandom);
         endcase
         if ($urandom_range(7) == 0) com1_base = com2_base;
         check(auto_tag());
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule